// File: doc/BRIEF.md
# Symmetric Two-Phase PWM Generator

This block produces two phases of center-aligned PWM for a motor drive. Each phase has a true output and a complementary output, so there are four outputs in all. The time base advances once per cycle of the block's input clock. The output frequency therefore follows whatever clock is fed in, and there is no divider inside the block. The carrier is a triangle: a position counter steps through a full period of 2^(CAR_W+1) clocks. Its ramp value rises over the first half of the period and falls over the second half.

A host loads a duty word and a phase word as parallel values, for example from a serial receive shift register, and pulses a load strobe. Both words go into a pending stage. They become active only at the carrier valley, which is the edge where the phase A position wraps back to zero. A phase output is high while its ramp is below the active duty word, so each pulse is centered on the valley. Phase B runs on its own position counter, which lags phase A by the active phase word taken modulo the period.

Top module: `sym_pwm2`

## Requirements
- R1: While rst_ni is low, and up to the first rising clock edge after it is released, all four outputs are low and both position counters are zero.
- R2: The phase A position advances by one on every clock and wraps from 2^(CAR_W+1)-1 to 0. Its ramp equals the position in the first half of the period and equals (2^(CAR_W+1)-1 minus the position) in the second half. With the defaults, that is 0..255 followed by 255..0.
- R3: After the first clock edge out of reset, pwm_o[0] (phase A) is high exactly when the phase A ramp, compared as an unsigned number, is below the active duty word. A duty of 0 keeps it always low. A duty of 2^CAR_W or more keeps it always high.
- R4: The phase B position equals (phase A position minus the active phase word) modulo 2^(CAR_W+1). pwm_o[1] is high exactly when the phase B ramp is below the active duty word.
- R5: After the first clock edge out of reset, pwm_n_o[i] is always the inverse of pwm_o[i] for both phases.
- R6: A clock edge with load_i high copies duty_i and phase_i into the pending stage. This does not change the outputs until the next valley.
- R7: The pending words become active only at the clock edge where the phase A position goes from its maximum to 0. A load taken on that same edge becomes active one full period later.
- R8: Only the low CAR_W+1 bits of the phase word matter. For example, a phase of 600 behaves like 88, and 1023 behaves like 511.
- R9: While load_i is low, changes on duty_i and phase_i have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Carrier time base; one position step per rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Strobe that captures duty_i and phase_i into the pending stage |
| duty_i | input | WORD_W | Duty word, compared against each phase's ramp |
| phase_i | input | WORD_W | Lag of phase B behind phase A, in clocks |
| pwm_o | output | 2 | True outputs; bit 0 is phase A, bit 1 is phase B |
| pwm_n_o | output | 2 | Complementary outputs, same bit order |

## Verification
The bench builds the block with its default values, CAR_W = 8 and WORD_W = 12. With these values a period is 512 clocks, short enough to run many full periods. The 12-bit words can then exceed the ramp range (duty 300) and the period (phase 600 and 1023), which exercises saturation and the modulo reduction. Some loads are timed to land mid-period and some to land exactly on the wrap edge, so the point at which new values take effect is pinned down on both sides.

// File: rtl/sym_pwm_pkg.sv
package sym_pwm_pkg;
  localparam int NUM_PH = 2;
  localparam int PH_A   = 0;
  localparam int PH_B   = 1;
endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs #(
  parameter int WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] duty_i,
  input  logic [WORD_W-1:0] phase_i,
  input  logic              valley_i,
  output logic [WORD_W-1:0] pend_phase_o,
  output logic [WORD_W-1:0] duty_o,
  output logic [WORD_W-1:0] phase_o
);
  logic [WORD_W-1:0] pend_duty_q, pend_phase_q, act_duty_q, act_phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_duty_q  <= '0;
      pend_phase_q <= '0;
      act_duty_q   <= '0;
      act_phase_q  <= '0;
    end else begin
      if (load_i) begin
        pend_duty_q  <= duty_i;
        pend_phase_q <= phase_i;
      end
      // swap at the valley only; the old pending value wins over a same-edge load
      if (valley_i) begin
        act_duty_q  <= pend_duty_q;
        act_phase_q <= pend_phase_q;
      end
    end
  end

  assign pend_phase_o = pend_phase_q;
  assign duty_o       = act_duty_q;
  assign phase_o      = act_phase_q;
endmodule

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
  parameter int CAR_W  = 8,
  parameter int WORD_W = 12,
  localparam int POS_W = CAR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] pend_phase_i,
  output logic [POS_W-1:0]  pos_a_o,
  output logic [POS_W-1:0]  pos_b_o,
  output logic              valley_o
);
  logic [POS_W-1:0] pos_a_q, pos_b_q;

  assign valley_o = &pos_a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_a_q <= '0;
      pos_b_q <= '0;
    end else begin
      pos_a_q <= pos_a_q + 1'b1;
      // phase B counter re-seeded with the incoming lag when A wraps
      if (valley_o) pos_b_q <= '0 - pend_phase_i[POS_W-1:0];
      else          pos_b_q <= pos_b_q + 1'b1;
    end
  end

  assign pos_a_o = pos_a_q;
  assign pos_b_o = pos_b_q;
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter int CAR_W  = 8,
  parameter int WORD_W = 12,
  localparam int POS_W = CAR_W + 1
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [WORD_W-1:0] duty_i,
  input  logic              en_i,
  output logic              p_o,
  output logic              n_o
);
  logic [CAR_W-1:0] ramp;
  logic             hit;

  // falling half mirrors the rising half
  assign ramp = pos_i[POS_W-1] ? ~pos_i[CAR_W-1:0] : pos_i[CAR_W-1:0];
  assign hit  = WORD_W'(ramp) < duty_i;
  assign p_o  = en_i & hit;
  assign n_o  = en_i & ~hit;
endmodule

// File: rtl/sym_pwm2.sv
module sym_pwm2 import sym_pwm_pkg::*; #(
  parameter int CAR_W  = 8,
  parameter int WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] duty_i,
  input  logic [WORD_W-1:0] phase_i,
  output logic [NUM_PH-1:0] pwm_o,
  output logic [NUM_PH-1:0] pwm_n_o
);
  localparam int POS_W = CAR_W + 1;

  logic [POS_W-1:0]  pos_a, pos_b;
  logic [POS_W-1:0]  pos_ph [NUM_PH];
  logic [WORD_W-1:0] pend_phase, duty_act, phase_act;
  logic              valley, run_q;

  pwm_ctrl_regs #(.WORD_W(WORD_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .duty_i(duty_i), .phase_i(phase_i), .valley_i(valley),
    .pend_phase_o(pend_phase), .duty_o(duty_act), .phase_o(phase_act)
  );

  pwm_carrier #(.CAR_W(CAR_W), .WORD_W(WORD_W)) u_car (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_phase_i(pend_phase),
    .pos_a_o(pos_a), .pos_b_o(pos_b), .valley_o(valley)
  );

  // keeps both pair outputs low until the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign pos_ph[PH_A] = pos_a;
  assign pos_ph[PH_B] = pos_b;

  for (genvar i = 0; i < NUM_PH; i++) begin : g_pair
    pwm_pair #(.CAR_W(CAR_W), .WORD_W(WORD_W)) u_pair (
      .pos_i(pos_ph[i]), .duty_i(duty_act), .en_i(run_q),
      .p_o(pwm_o[i]), .n_o(pwm_n_o[i])
    );
  end
endmodule

// File: rtl/sym_pwm2_chk.sv
module sym_pwm2_chk #(
  parameter int CAR_W  = 8,
  parameter int WORD_W = 12,
  localparam int POS_W = CAR_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        pwm_o,
  input logic [1:0]        pwm_n_o,
  input logic [POS_W-1:0]  pos_a,
  input logic [POS_W-1:0]  pos_b,
  input logic [WORD_W-1:0] duty_act,
  input logic [WORD_W-1:0] phase_act
);
  logic started;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) assert_reset_low_R1: assert (pwm_o == '0 && pwm_n_o == '0);
  end

  assert_carrier_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> pos_a == POS_W'($past(pos_a) + 1'b1));

  assert_duty_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_act == '0) |-> pwm_o == '0);

  assert_phase_lag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_b == POS_W'(pos_a - phase_act[POS_W-1:0]));

  assert_pair_inverse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> pwm_n_o == ~pwm_o);

  assert_valley_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_a != '0) |-> ($stable(duty_act) && $stable(phase_act)));
endmodule

bind sym_pwm2 sym_pwm2_chk #(.CAR_W(CAR_W), .WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o),
  .pos_a(pos_a), .pos_b(pos_b), .duty_act(duty_act), .phase_act(phase_act)
);

// File: tb/sim_sym_pwm2.sv
module sim_sym_pwm2;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [11:0] duty = '0;
  logic [11:0] phase = '0;
  logic [1:0]  pwm, pwm_n;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  int pos_m = 0, pend_d = 0, pend_p = 0, act_d = 0, act_p = 0;
  bit started_m = 0;
  string tag = "R1";

  sym_pwm2 u0 (.clk_i(clk), .rst_ni(rst_n), .load_i(load), .duty_i(duty),
               .phase_i(phase), .pwm_o(pwm), .pwm_n_o(pwm_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ramp_f(int p);
    return (p < PER/2) ? p : PER - 1 - p;
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_m = 0; pend_d = 0; pend_p = 0; act_d = 0; act_p = 0; started_m = 0;
    end else begin
      if (pos_m == PER - 1) begin act_d = pend_d; act_p = pend_p; end
      if (load) begin pend_d = int'(duty); pend_p = int'(phase); end
      pos_m = (pos_m + 1) % PER;
      started_m = 1;
    end
  end

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (scenario %s) at pos %0d: got %b expected %b", req, tag, pos_m, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic ea, eb;
    int pb;
    if (!rst_n || !started_m) begin
      chk("R1", pwm, 2'b00);
      chk("R1", pwm_n, 2'b00);
    end else begin
      pb = (pos_m - (act_p % PER) + PER) % PER;
      ea = ramp_f(pos_m) < act_d;
      eb = ramp_f(pb) < act_d;
      chk("R3", {1'b0, pwm[0]}, {1'b0, ea});
      chk("R4", {1'b0, pwm[1]}, {1'b0, eb});
      chk("R5", pwm_n, ~pwm);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic load_word(int d, int p);
    @(posedge clk); #1;
    load = 1'b1; duty = 12'(d); phase = 12'(p);
    @(posedge clk); #1;
    load = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    tag = "R1";
    run(3);
    @(posedge clk); #1 rst_n = 1'b1;
    tag = "R3"; run(600);
    tag = "R6"; load_word(100, 0); run(1100);
    tag = "R4"; load_word(200, 128); run(1100);
    tag = "R8"; load_word(300, 600); run(1100);
    load_word(60, 1023); run(1100);
    tag = "R2"; load_word(255, 0); run(1100);
    tag = "R7";
    do begin @(posedge clk); #1; end while (pos_m != PER - 1);
    load = 1'b1; duty = 12'd150; phase = 12'd256;
    @(posedge clk); #1 load = 1'b0;
    run(1100);
    tag = "R9";
    for (int i = 0; i < 1100; i++) begin
      @(posedge clk); #1;
      duty = 12'((i * 37) % 4096); phase = 12'((i * 91) % 4096);
    end
    run(10);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule